// File: doc/BRIEF.md
# Two-Key Register Write-Protect Gate

This block stands between a simple register-bus write port and a peripheral register file, and it decides whether each bus write may reach the file. After reset the file is write-protected. Software opens it by writing two fixed 32-bit magic words to two dedicated key addresses. The first key address must be written first and the second key address must be written next. A wrong value at either address closes the file again. Writing zero, or any other wrong value, to the first key address is therefore the normal way to re-protect the file.

The gate has three states: locked, armed (the first key is accepted) and open. These are reported on a status output. Writes to the key addresses are consumed by the gate and never reach the register file. A write that is accepted is forwarded one cycle later through registered outputs: a write-enable qualifier, the address and the data. Reads pass through a registered mask that returns zero for both key addresses, so the magic words can never be read back.

Top module: `regwp_gate`

## Requirements
- R1: While `rst` is high at a clock edge, after that edge `lock_state` is 0 (locked), `rf_wr_en` is 0 and `bus_rdata` is 0.
- R2: In the locked state (code 0), a write to any address other than the two key addresses is dropped, so `rf_wr_en` stays 0 in the following cycle.
- R3: A write of 0x83E70B13 to address 0x6C moves the gate to the armed state (code 1) in the following cycle, whatever the state was before.
- R4: In the armed state, a write of 0x95A4F1E0 to address 0x70 moves the gate to the open state (code 2) in the following cycle.
- R5: In the open state, a write to a non-key address is forwarded: in the following cycle `rf_wr_en` is 1, and `rf_addr` and `rf_wdata` carry that write's address and data.
- R6: A write to address 0x6C or 0x70 never causes `rf_wr_en` in the following cycle.
- R7: A write to address 0x6C of any value other than 0x83E70B13 (zero included) returns the gate to the locked state in the following cycle.
- R8: In the armed state, a write to address 0x70 of any value other than 0x95A4F1E0 returns the gate to the locked state.
- R9: In the armed state, a write to a non-key address breaks the sequence: the write is dropped and the gate returns to the locked state.
- R10: A write to address 0x70 while locked or open is ignored, and `lock_state` stays unchanged.
- R11: `bus_rdata` equals `rf_rdata` of the previous cycle when the previous `bus_addr` was a non-key address, and 0 when it was 0x6C or 0x70.
- R12: A correct first key written while open moves the gate back to the armed state, where protected writes are dropped.
- R13: `lock_state` never shows code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W (8) | Byte address for the write and the read |
| bus_wdata | input | DATA_W (32) | Write data |
| rf_rdata | input | DATA_W (32) | Read data from the register file for `bus_addr` |
| rf_wr_en | output | 1 | Qualified write enable to the register file (registered) |
| rf_addr | output | ADDR_W (8) | Address of the forwarded write |
| rf_wdata | output | DATA_W (32) | Data of the forwarded write |
| bus_rdata | output | DATA_W (32) | Masked read data (registered) |
| lock_state | output | 2 | 0 locked, 1 armed, 2 open |

## Verification
Directed sequences cover several cases: the clean unlock, a relock with zero, a wrong second key, a protected write inserted between the two keys, a second key with no first key, and a first key re-issued while open. Each case separates one transition rule from its neighbours. Random traffic then draws addresses mostly from the two key offsets, and data mostly from the two magic words and zero, so that every state sees every kind of write many times. This traffic exposes mistakes in state ordering, and forwarding from the wrong state, which directed cases alone could miss. Read masking is checked on every cycle against random file data.

// File: rtl/regwp_pkg.sv
package regwp_pkg;
  typedef enum logic [1:0] {
    LK_LOCKED = 2'd0,
    LK_ARMED  = 2'd1,
    LK_OPEN   = 2'd2
  } lock_state_e;
endpackage

// File: rtl/regwp_addr_decode.sv
module regwp_addr_decode #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_key0,
  output logic              hit_key1,
  output logic              hit_any
);
  always_comb begin
    hit_key0 = (addr == KEY0_ADDR);
    hit_key1 = (addr == KEY1_ADDR);
    hit_any  = hit_key0 | hit_key1;
  end
endmodule

// File: rtl/regwp_key_fsm.sv
module regwp_key_fsm
  import regwp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter logic [DATA_W-1:0] KEY0_VAL = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1_VAL = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              hit_key0,
  input  logic              hit_key1,
  input  logic [DATA_W-1:0] wdata,
  output lock_state_e       state
);
  lock_state_e state_d;

  always_comb begin
    state_d = state;
    if (wr_en) begin
      if (hit_key0) begin
        // first key always restarts the sequence
        state_d = (wdata == KEY0_VAL) ? LK_ARMED : LK_LOCKED;
      end else if (hit_key1) begin
        if (state == LK_ARMED)
          state_d = (wdata == KEY1_VAL) ? LK_OPEN : LK_LOCKED;
      end else if (state == LK_ARMED) begin
        // any other write between the keys breaks the sequence
        state_d = LK_LOCKED;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= LK_LOCKED;
    else     state <= state_d;
  end
endmodule

// File: rtl/regwp_write_gate.sv
module regwp_write_gate
  import regwp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              hit_any,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  lock_state_e       state,
  output logic              rf_wr_en,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata
);
  logic pass;
  assign pass = wr_en && !hit_any && (state == LK_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_wr_en <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
    end else begin
      rf_wr_en <= pass;
      if (pass) begin
        rf_addr  <= addr;
        rf_wdata <= wdata;
      end
    end
  end
endmodule

// File: rtl/regwp_read_mask.sv
module regwp_read_mask #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit_any,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [DATA_W-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst)          bus_rdata <= '0;
    else if (hit_any) bus_rdata <= '0;
    else              bus_rdata <= rf_rdata;
  end
endmodule

// File: rtl/regwp_gate.sv
module regwp_gate
  import regwp_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_VAL  = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1_VAL  = 32'h95A4F1E0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic              rf_wr_en,
  output logic [ADDR_W-1:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [1:0]        lock_state
);
  logic        hit_key0, hit_key1, hit_any;
  lock_state_e state;

  regwp_addr_decode #(
    .ADDR_W(ADDR_W), .KEY0_ADDR(KEY0_ADDR), .KEY1_ADDR(KEY1_ADDR)
  ) u_dec (
    .addr(bus_addr), .hit_key0(hit_key0), .hit_key1(hit_key1), .hit_any(hit_any)
  );

  regwp_key_fsm #(
    .DATA_W(DATA_W), .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
  ) u_fsm (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .hit_key0(hit_key0),
    .hit_key1(hit_key1), .wdata(bus_wdata), .state(state)
  );

  regwp_write_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .hit_any(hit_any),
    .addr(bus_addr), .wdata(bus_wdata), .state(state),
    .rf_wr_en(rf_wr_en), .rf_addr(rf_addr), .rf_wdata(rf_wdata)
  );

  regwp_read_mask #(.DATA_W(DATA_W)) u_rmask (
    .clk(clk), .rst(rst), .hit_any(hit_any), .rf_rdata(rf_rdata),
    .bus_rdata(bus_rdata)
  );

  assign lock_state = state;
endmodule

// File: rtl/regwp_gate_chk.sv
module regwp_gate_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_VAL  = 32'h83E70B13,
  parameter logic [DATA_W-1:0] KEY1_VAL  = 32'h95A4F1E0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr_en,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rf_wr_en,
  input logic [DATA_W-1:0] rf_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [1:0]        lock_state
);
  logic is_k0, is_k1, is_key;
  assign is_k0  = bus_addr == KEY0_ADDR;
  assign is_k1  = bus_addr == KEY1_ADDR;
  assign is_key = is_k0 || is_k1;

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (lock_state == 2'd0 && !rf_wr_en && bus_rdata == '0));

  assert_locked_drop_R2: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd0 && bus_wr_en && !is_key) |=> !rf_wr_en);

  assert_key0_arms_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && is_k0 && bus_wdata == KEY0_VAL) |=> lock_state == 2'd1);

  assert_key1_opens_R4: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd1 && bus_wr_en && is_k1 && bus_wdata == KEY1_VAL)
    |=> lock_state == 2'd2);

  assert_open_forward_R5: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd2 && bus_wr_en && !is_key)
    |=> (rf_wr_en && rf_wdata == $past(bus_wdata)));

  assert_key_not_forwarded_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && is_key) |=> !rf_wr_en);

  assert_bad_key0_locks_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && is_k0 && bus_wdata != KEY0_VAL) |=> lock_state == 2'd0);

  assert_bad_key1_locks_R8: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd1 && bus_wr_en && is_k1 && bus_wdata != KEY1_VAL)
    |=> lock_state == 2'd0);

  assert_break_sequence_R9: assert property (@(posedge clk) disable iff (rst)
    (lock_state == 2'd1 && bus_wr_en && !is_key)
    |=> (lock_state == 2'd0 && !rf_wr_en));

  assert_stray_key1_R10: assert property (@(posedge clk) disable iff (rst)
    (lock_state != 2'd1 && bus_wr_en && is_k1) |=> $stable(lock_state));

  assert_key_read_zero_R11: assert property (@(posedge clk) disable iff (rst)
    is_key |=> bus_rdata == '0);

  assert_legal_code_R13: assert property (@(posedge clk) disable iff (rst)
    lock_state != 2'd3);
endmodule

bind regwp_gate regwp_gate_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY0_ADDR(KEY0_ADDR),
  .KEY1_ADDR(KEY1_ADDR), .KEY0_VAL(KEY0_VAL), .KEY1_VAL(KEY1_VAL)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .rf_wr_en(rf_wr_en), .rf_wdata(rf_wdata),
  .bus_rdata(bus_rdata), .lock_state(lock_state)
);

// File: tb/tb_regwp_gate.sv
module tb_regwp_gate;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  K0A = 8'h6C;
  localparam logic [7:0]  K1A = 8'h70;
  localparam logic [31:0] K0V = 32'h83E70B13;
  localparam logic [31:0] K1V = 32'h95A4F1E0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr_en = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rf_rdata = '0;
  logic        rf_wr_en;
  logic [7:0]  rf_addr;
  logic [31:0] rf_wdata;
  logic [31:0] bus_rdata;
  logic [1:0]  lock_state;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // model state and predictions for the next sampling point
  logic [1:0]  m_state = 2'd0;
  logic [1:0]  e_state = 2'd0;
  logic        e_wen = 1'b0;
  logic [7:0]  e_addr = '0;
  logic [31:0] e_wdata = '0;
  logic [31:0] e_rdata = '0;
  string       e_tag = "R1";
  string       e_wtag = "R1";
  string       e_rtag = "R1";

  regwp_gate dut (
    .clk(clk), .rst(rst), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rf_rdata(rf_rdata), .rf_wr_en(rf_wr_en),
    .rf_addr(rf_addr), .rf_wdata(rf_wdata), .bus_rdata(bus_rdata),
    .lock_state(lock_state)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit is_key(input logic [7:0] a);
    return (a == K0A) || (a == K1A);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // compare outputs against the predictions for this cycle
  task automatic compare();
    check(e_tag, "lock_state", {30'd0, lock_state}, {30'd0, e_state});
    check(e_wtag, "rf_wr_en", {31'd0, rf_wr_en}, {31'd0, e_wen});
    if (e_wen) begin
      check("R5", "rf_addr", {24'd0, rf_addr}, {24'd0, e_addr});
      check("R5", "rf_wdata", rf_wdata, e_wdata);
    end
    check(e_rtag, "bus_rdata", bus_rdata, e_rdata);
  endtask

  // one bus cycle: drive at negedge, predict the result of the next edge
  task automatic cycle(input logic we, input logic [7:0] a, input logic [31:0] d);
    logic [1:0] nx;
    @(negedge clk);
    compare();
    bus_wr_en = we;
    bus_addr  = a;
    bus_wdata = d;
    rf_rdata  = $urandom;
    nx = m_state;
    e_tag = "R10";
    if (we) begin
      if (a == K0A) begin
        if (d == K0V) begin nx = 2'd1; e_tag = (m_state == 2'd2) ? "R12" : "R3"; end
        else          begin nx = 2'd0; e_tag = "R7"; end
      end else if (a == K1A) begin
        if (m_state == 2'd1) begin
          if (d == K1V) begin nx = 2'd2; e_tag = "R4"; end
          else          begin nx = 2'd0; e_tag = "R8"; end
        end else e_tag = "R10";
      end else if (m_state == 2'd1) begin
        nx = 2'd0; e_tag = "R9";
      end else e_tag = (m_state == 2'd0) ? "R2" : "R5";
    end
    e_wen  = we && !is_key(a) && (m_state == 2'd2);
    e_wtag = (we && is_key(a)) ? "R6" : (m_state == 2'd0) ? "R2" :
             (m_state == 2'd1) ? "R9" : "R5";
    if (e_wen) begin e_addr = a; e_wdata = d; end
    e_rdata = is_key(a) ? 32'd0 : rf_rdata;
    e_rtag  = "R11";
    m_state = nx;
    e_state = nx;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state observed first
    e_tag = "R1"; e_wtag = "R1"; e_rtag = "R1";
    // R2 locked drop
    cycle(1, 8'h10, 32'hDEAD0001);
    cycle(0, 8'h00, 0);
    // R3 / R4 clean unlock then R5 forward
    cycle(1, K0A, K0V);
    cycle(1, K1A, K1V);
    cycle(1, 8'h20, 32'hA5A5_0002);
    cycle(1, 8'h24, 32'h1234_5678);
    // R6 key writes not forwarded while open, R10 stray second key
    cycle(1, K1A, 32'h0);
    cycle(1, K1A, K1V);
    // R12 re-arm from open, protected write dropped (R9)
    cycle(1, K0A, K0V);
    cycle(1, 8'h30, 32'h0BAD_0003);
    // R7 relock with zero
    cycle(1, K0A, K0V);
    cycle(1, K1A, K1V);
    cycle(1, K0A, 32'h0);
    cycle(1, 8'h30, 32'h0BAD_0004);
    // R8 wrong second key
    cycle(1, K0A, K0V);
    cycle(1, K1A, 32'h95A4F1E1);
    cycle(1, K1A, K1V);
    // R10 second key without first
    cycle(1, K1A, K1V);
    // R9 interrupted sequence then second key
    cycle(1, K0A, K0V);
    cycle(1, 8'h04, 32'h1);
    cycle(1, K1A, K1V);
    // R11 reads of keys, idle read of key while bus_wr_en low
    cycle(0, K0A, 32'h0);
    cycle(0, K1A, 32'h0);
    cycle(0, 8'h44, 32'h0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      int sel;
      sel = $urandom_range(0, 9);
      a = (sel < 4) ? K0A : (sel < 7) ? K1A : 8'($urandom);
      sel = $urandom_range(0, 9);
      d = (sel < 3) ? K0V : (sel < 6) ? K1V : (sel < 7) ? 32'd0 : $urandom;
      cycle(1'($urandom_range(0, 3) != 0), a, d);
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule